// File: doc/BRIEF.md
# Cache-line burst cycle responder

This block sits on the system side of a processor's 64-bit memory bus and answers each memory cycle the processor starts. When the address strobe is seen while no cycle is in progress, it latches the quadword address, the direction, the cache-request flag and the byte enables. It then runs either one transfer or a four-beat line transfer against a simple memory port whose read data is valid in the same clock as the address. It produces one ready pulse per beat.

For reads, the responder itself decides between a single transfer and a line fill. The line fill happens only when the processor asks for a cacheable read and the system's `line_ok_i` input allows it. The decision is reported by raising the cache-enable output together with the first ready. A line fill returns all eight bytes of every quadword. A single read returns only the lanes that were enabled. Writes that carry the cache-request flag are treated as modified-line writebacks and always take four beats. Writes without it are single write-throughs that touch only the enabled lanes.

The responder computes every beat address itself. It starts from the quadword the processor asked for and walks the 32-byte line in interleaved order by default. A parameter selects a wrapping linear order instead.

Top module: `line_burst_responder`

## Requirements
- R1: A cycle accepted at a clock edge produces ready on the following consecutive clocks. A line cycle gives exactly four ready clocks. A single cycle gives exactly one. Ready is low in the clock after the last beat.
- R2: A read is a line fill only if `cache_req_i` and `line_ok_i` were both high with the accepted strobe. `cache_en_o` is high only in the first ready clock of a line fill and is low for single reads and for all writes.
- R3: On beat n (n = 0..3), `mem_addr_o` keeps the upper bits of the strobe address and carries quadword index (start index XOR n) in bits 1:0, which correspond to byte address bits 4:3.
- R4: On a single read, `rdata_o` byte lane k (bits 8k+7:8k) equals the memory byte when byte-enable bit k was set at the strobe, and is zero otherwise.
- R5: Byte enables are sampled only with the accepted strobe. Changes to `byte_en_i` during the beats have no effect, and a line fill returns all eight bytes on every beat.
- R6: A write with `cache_req_i` high is a four-beat writeback that writes all eight lanes on every beat. A write without it is one beat that writes only the enabled lanes. Each beat writes `wdata_i` as presented in that ready clock.
- R7: A strobe seen while a cycle is in progress, including the clock of its last ready, is ignored. It raises `busy_err_o` for one clock in the following clock, and the current cycle's beats, addresses and writes are unchanged.
- R8: After reset, `ready_o`, `cache_en_o`, `mem_we_o` and `busy_err_o` are low.
- R9: Outside ready clocks, `mem_we_o` is low and `rdata_o` is zero. During reads, `mem_we_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_i | input | 1 | Address strobe that starts a cycle |
| write_i | input | 1 | 1 = write cycle, 0 = read cycle |
| cache_req_i | input | 1 | Processor requests a line-sized cycle |
| line_ok_i | input | 1 | System allows a line fill for this read |
| byte_en_i | input | 8 | Byte-lane enables, bit k selects lane k |
| qw_addr_i | input | ADDR_W | Quadword address (byte address bits above 2) |
| wdata_i | input | 64 | Processor write data for the current beat |
| ready_o | output | 1 | One pulse per completed beat |
| cache_en_o | output | 1 | Line-fill answer, given with the first ready |
| rdata_o | output | 64 | Read data returned to the processor |
| busy_err_o | output | 1 | Strobe arrived while a cycle was in progress |
| mem_addr_o | output | ADDR_W | Quadword address toward memory |
| mem_we_o | output | 1 | Memory write enable |
| mem_wstrb_o | output | 8 | Memory byte-lane write strobes |
| mem_wdata_o | output | 64 | Memory write data |
| mem_rdata_i | input | 64 | Memory read data, valid in the same clock as the address |

## Verification
The assertions assume that the memory port answers combinationally. They also assume that the processor keeps the strobe low at least one clock between cycles, so that a stray strobe is a deliberate error case rather than normal traffic. The stimulus follows this rule for all table-driven cycles. It raises the strobe during a line only in the one directed test that checks the busy flag. Byte enables and write data change only at the falling clock edge. Byte enables are deliberately scrambled during the beats to show that only the strobe-time value matters.

// File: rtl/lbr_pkg.sv
package lbr_pkg;
   // Order in which the beats of one line visit its quadwords.
   typedef enum logic {
      ORDER_INTERLEAVED = 1'b0,
      ORDER_LINEAR      = 1'b1
   } beat_order_e;
endpackage

// File: rtl/lbr_seq.sv
module lbr_seq #(
   parameter int BEATS = 4,
   localparam int IDX_W = $clog2(BEATS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strobe_i,
   input  logic             write_i,
   input  logic             cache_req_i,
   input  logic             line_ok_i,
   output logic             accept_o,
   output logic             active_o,
   output logic [IDX_W-1:0] beat_o,
   output logic             burst_o,
   output logic             write_o,
   output logic             err_o
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BEATS - 1);

   logic             active_q, burst_q, write_q, err_q;
   logic [IDX_W-1:0] beat_q;
   logic             last_beat;

   assign accept_o  = strobe_i && !active_q;
   assign last_beat = !burst_q || (beat_q == LAST_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         burst_q  <= 1'b0;
         write_q  <= 1'b0;
         beat_q   <= '0;
         err_q    <= 1'b0;
      end else begin
         err_q <= strobe_i && active_q;
         if (accept_o) begin
            active_q <= 1'b1;
            beat_q   <= '0;
            write_q  <= write_i;
            // writebacks are lines by request; reads need the system's consent
            burst_q  <= write_i ? cache_req_i : (cache_req_i && line_ok_i);
         end else if (active_q) begin
            if (last_beat) active_q <= 1'b0;
            else           beat_q   <= beat_q + 1'b1;
         end
      end
   end

   assign active_o = active_q;
   assign beat_o   = beat_q;
   assign burst_o  = burst_q;
   assign write_o  = write_q;
   assign err_o    = err_q;

   p_line_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
      active_q && burst_q && (beat_q != LAST_IDX) |=> active_q && (beat_q == $past(beat_q) + 1'b1));
   p_single_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
      active_q && !burst_q |=> !active_q);
   p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active_q) |-> $past(strobe_i) && (beat_q == '0));
   p_err_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> $past(strobe_i) && $past(active_q));
endmodule

// File: rtl/lbr_addr_gen.sv
module lbr_addr_gen
   import lbr_pkg::*;
#(
   parameter int          ADDR_W = 13,
   parameter int          BEATS  = 4,
   parameter beat_order_e ORDER  = ORDER_INTERLEAVED,
   localparam int IDX_W  = $clog2(BEATS),
   localparam int LINE_W = ADDR_W - IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              active_i,
   input  logic [ADDR_W-1:0] qw_addr_i,
   input  logic [IDX_W-1:0]  beat_i,
   output logic [ADDR_W-1:0] mem_addr_o
);
   logic [LINE_W-1:0] line_q;
   logic [IDX_W-1:0]  start_q;
   logic [IDX_W-1:0]  idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q  <= '0;
         start_q <= '0;
      end else if (load_i) begin
         line_q  <= qw_addr_i[ADDR_W-1:IDX_W];
         start_q <= qw_addr_i[IDX_W-1:0];
      end
   end

   generate
      if (ORDER == ORDER_INTERLEAVED) begin : g_interleave
         assign idx = start_q ^ beat_i;
      end else begin : g_linear
         assign idx = start_q + beat_i;
      end
   endgenerate

   assign mem_addr_o = {line_q, idx};

   p_line_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      active_i && $past(active_i) |-> $stable(mem_addr_o[ADDR_W-1:IDX_W]));
endmodule

// File: rtl/lbr_lane_mask.sv
module lbr_lane_mask #(
   parameter int LANES = 8,
   localparam int DATA_W = LANES * 8
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic [LANES-1:0]  lane_en_i,
   output logic [DATA_W-1:0] data_o
);
   generate
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         assign data_o[k*8 +: 8] = lane_en_i[k] ? data_i[k*8 +: 8] : 8'h00;
      end
   endgenerate
endmodule

// File: rtl/line_burst_responder.sv
module line_burst_responder
   import lbr_pkg::*;
#(
   parameter int          ADDR_W = 13,
   parameter int          DATA_W = 64,
   parameter int          BEATS  = 4,
   parameter beat_order_e ORDER  = ORDER_INTERLEAVED,
   localparam int LANES = DATA_W / 8,
   localparam int IDX_W = $clog2(BEATS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe_i,
   input  logic              write_i,
   input  logic              cache_req_i,
   input  logic              line_ok_i,
   input  logic [LANES-1:0]  byte_en_i,
   input  logic [ADDR_W-1:0] qw_addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              ready_o,
   output logic              cache_en_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic              busy_err_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic              mem_we_o,
   output logic [LANES-1:0]  mem_wstrb_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   input  logic [DATA_W-1:0] mem_rdata_i
);
   initial begin
      a_lanes: assert (DATA_W % 8 == 0 && DATA_W >= 8) else $error("DATA_W must be whole bytes");
      a_beats: assert (BEATS >= 2 && (1 << IDX_W) == BEATS) else $error("BEATS must be a power of two");
      a_addr:  assert (ADDR_W > IDX_W) else $error("ADDR_W must exceed the beat index width");
   end

   logic             accept, active, burst_q, write_q;
   logic [IDX_W-1:0] beat;
   logic [LANES-1:0] be_q;
   logic [LANES-1:0] rd_lanes;

   lbr_seq #(.BEATS(BEATS)) u_seq (
      .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i), .write_i(write_i),
      .cache_req_i(cache_req_i), .line_ok_i(line_ok_i), .accept_o(accept),
      .active_o(active), .beat_o(beat), .burst_o(burst_q), .write_o(write_q),
      .err_o(busy_err_o));

   lbr_addr_gen #(.ADDR_W(ADDR_W), .BEATS(BEATS), .ORDER(ORDER)) u_addr (
      .clk(clk), .rst_n(rst_n), .load_i(accept), .active_i(active),
      .qw_addr_i(qw_addr_i), .beat_i(beat), .mem_addr_o(mem_addr_o));

   // enables are captured once per cycle and never re-decoded per beat
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      be_q <= '0;
      else if (accept) be_q <= byte_en_i;
   end

   assign ready_o     = active;
   assign cache_en_o  = active && burst_q && !write_q && (beat == '0);
   assign mem_we_o    = active && write_q;
   assign mem_wstrb_o = burst_q ? '1 : be_q;
   assign mem_wdata_o = wdata_i;
   assign rd_lanes    = (active && !write_q) ? (burst_q ? '1 : be_q) : '0;

   lbr_lane_mask #(.LANES(LANES)) u_mask (
      .data_i(mem_rdata_i), .lane_en_i(rd_lanes), .data_o(rdata_o));

   p_ken_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cache_en_o |-> $rose(ready_o) && !mem_we_o);
   p_we_in_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> ready_o);
   p_rdata_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !ready_o |-> (rdata_o == '0));
   p_full_lanes_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o && !$rose(ready_o) |-> (mem_wstrb_o == '1));
   p_enables_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o && $past(ready_o) |-> $stable(mem_wstrb_o));
endmodule

// File: tb/sim_line_burst_responder.sv
module sim_line_burst_responder;
   localparam int CLK_P = 10;
   localparam int NV = 11;
   // vector fields: {write, cache_req, line_ok, byte_en[7:0], qw_addr[5:0]}
   localparam logic [16:0] VEC [0:NV-1] = '{
      {1'b0, 1'b1, 1'b1, 8'h0F, 6'd4},
      {1'b0, 1'b1, 1'b1, 8'hF0, 6'd5},
      {1'b0, 1'b1, 1'b1, 8'h01, 6'd10},
      {1'b0, 1'b1, 1'b1, 8'hFF, 6'd15},
      {1'b0, 1'b1, 1'b0, 8'h3C, 6'd6},
      {1'b0, 1'b0, 1'b1, 8'hFF, 6'd7},
      {1'b1, 1'b1, 1'b0, 8'h00, 6'd9},
      {1'b0, 1'b1, 1'b1, 8'h00, 6'd8},
      {1'b1, 1'b0, 1'b0, 8'hA5, 6'd13},
      {1'b0, 1'b0, 1'b0, 8'hFF, 6'd13},
      {1'b0, 1'b1, 1'b1, 8'h80, 6'd14}
   };

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        strobe = 1'b0, wr = 1'b0, creq = 1'b0, lok = 1'b0;
   logic [7:0]  be = '0;
   logic [12:0] qa = '0;
   logic [63:0] wdata = '0;
   logic        ready, cache_en, busy_err, mem_we;
   logic [63:0] rdata, mem_wdata, mem_rdata;
   logic [12:0] mem_addr;
   logic [7:0]  mem_wstrb;

   logic [63:0] mem [0:63];
   logic [63:0] shadow [0:63];
   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #(CLK_P/2) clk = ~clk;

   line_burst_responder u0 (
      .clk(clk), .rst_n(rst_n), .strobe_i(strobe), .write_i(wr), .cache_req_i(creq),
      .line_ok_i(lok), .byte_en_i(be), .qw_addr_i(qa), .wdata_i(wdata),
      .ready_o(ready), .cache_en_o(cache_en), .rdata_o(rdata), .busy_err_o(busy_err),
      .mem_addr_o(mem_addr), .mem_we_o(mem_we), .mem_wstrb_o(mem_wstrb),
      .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata));

   assign mem_rdata = mem[mem_addr[5:0]];
   always @(posedge clk)
      if (mem_we)
         for (int k = 0; k < 8; k++)
            if (mem_wstrb[k]) mem[mem_addr[5:0]][k*8 +: 8] <= mem_wdata[k*8 +: 8];

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] lane_mask(input logic [7:0] en);
      logic [63:0] m;
      for (int k = 0; k < 8; k++) m[k*8 +: 8] = en[k] ? 8'hFF : 8'h00;
      return m;
   endfunction

   task automatic run_cycle(input logic w, input logic c, input logic a,
                            input logic [7:0] en, input logic [5:0] addr);
      bit line = w ? c : (c && a);
      int nb = line ? 4 : 1;
      @(negedge clk);
      strobe = 1'b1; wr = w; creq = c; lok = a; be = en; qa = {7'd0, addr};
      for (int n = 0; n < nb; n++) begin
         logic [5:0]  ea;
         logic [63:0] exp_rd;
         @(negedge clk);
         strobe = 1'b0;
         be = ~en;   // R5: changes during beats must not matter
         wdata = 64'hD00D_0000_0000_0000 | {50'd0, addr, 8'(n)};
         #1;
         ea = {addr[5:2], addr[1:0] ^ 2'(n)};
         chk(ready === 1'b1, "R1 ready per beat", {63'd0, ready}, 64'd1);
         chk(mem_addr[5:0] === ea, "R3 beat address", {58'd0, mem_addr[5:0]}, {58'd0, ea});
         chk(cache_en === (n == 0 && !w && line), "R2 cache enable", {63'd0, cache_en},
             {63'd0, (n == 0 && !w && line)});
         if (!w) begin
            exp_rd = line ? shadow[ea] : (shadow[ea] & lane_mask(en));
            chk(rdata === exp_rd, line ? "R5 full line data" : "R4 single masked data", rdata, exp_rd);
            chk(mem_we === 1'b0, "R9 no write on read", {63'd0, mem_we}, 64'd0);
         end else begin
            logic [7:0] es = line ? 8'hFF : en;
            chk(mem_we === 1'b1 && mem_wstrb === es, "R6 write lanes", {55'd0, mem_we, mem_wstrb},
                {55'd0, 1'b1, es});
            for (int k = 0; k < 8; k++)
               if (es[k]) shadow[ea][k*8 +: 8] = wdata[k*8 +: 8];
         end
      end
      @(negedge clk); #1;
      chk(ready === 1'b0 && rdata === 64'd0 && mem_we === 1'b0, "R1 R9 quiet after last beat",
          {62'd0, ready, mem_we}, 64'd0);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) begin
         mem[i]    = 64'(i) * 64'h0101_0101_0101_0101 + 64'h7060_5040_3020_1000;
         shadow[i] = mem[i];
      end
      repeat (3) @(negedge clk);
      #1;
      chk(ready === 1'b0 && cache_en === 1'b0 && mem_we === 1'b0 && busy_err === 1'b0,
          "R8 reset state", {60'd0, ready, cache_en, mem_we, busy_err}, 64'd0);
      @(negedge clk); rst_n = 1'b1;

      for (int v = 0; v < NV; v++)
         run_cycle(VEC[v][16], VEC[v][15], VEC[v][14], VEC[v][13:6], VEC[v][5:0]);

      // R7: strobe during a line fill is ignored and flagged
      @(negedge clk);
      strobe = 1'b1; wr = 1'b0; creq = 1'b1; lok = 1'b1; be = 8'hFF; qa = 13'd22;
      @(negedge clk); strobe = 1'b0; #1;
      chk(mem_addr[5:0] === 6'd22, "R3 beat0 of interrupted line", {58'd0, mem_addr[5:0]}, 64'd22);
      @(negedge clk);
      strobe = 1'b1; wr = 1'b1; creq = 1'b0; be = 8'hFF; qa = 13'd40; wdata = '1;
      #1;
      chk(mem_addr[5:0] === 6'd23 && mem_we === 1'b0, "R7 busy strobe no effect",
          {57'd0, mem_we, mem_addr[5:0]}, 64'd23);
      @(negedge clk); strobe = 1'b0; #1;
      chk(busy_err === 1'b1, "R7 busy flag raised", {63'd0, busy_err}, 64'd1);
      chk(mem_addr[5:0] === 6'd20 && rdata === shadow[20], "R7 line continues",
          rdata, shadow[20]);
      @(negedge clk); #1;
      chk(busy_err === 1'b0 && ready === 1'b1 && mem_addr[5:0] === 6'd21, "R7 flag one clock",
          {56'd0, busy_err, ready, mem_addr[5:0]}, {56'd0, 2'b01, 6'd21});
      @(negedge clk); #1;
      chk(ready === 1'b0, "R1 four beats only", {63'd0, ready}, 64'd0);
      chk(mem[40] === shadow[40], "R7 ignored write left memory", mem[40], shadow[40]);

      // R7: strobe in the clock of the last ready of a single read
      @(negedge clk);
      strobe = 1'b1; wr = 1'b0; creq = 1'b0; lok = 1'b0; be = 8'h01; qa = 13'd3;
      @(negedge clk); #1;
      chk(ready === 1'b1, "R1 single beat", {63'd0, ready}, 64'd1);
      @(negedge clk); strobe = 1'b0; #1;
      chk(busy_err === 1'b1 && ready === 1'b0, "R7 strobe on last ready dropped",
          {62'd0, busy_err, ready}, {62'd0, 2'b10});

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(CLK_P * 20000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule